// File: doc/BRIEF.md
# Clock Divider and Power Mode Unit

This block turns the incoming oscillator clock, which runs at twice the processor rate, into the timing that the rest of a processor subsystem uses. The block does not generate new clocks. It issues single-cycle enable pulses, one for the CPU domain and one for the peripheral domain, together with a clock output at the processor rate that has an even duty cycle. The enables and the clock output all come from one shared counter, so they stay in phase.

Software picks one of three low-power behaviours through a control register. Idle freezes only the CPU enable. Powerdown freezes every enable and holds the clock output. Powersave slows every enable by a selectable prescale factor, and a change of factor waits for the end of the divided period that is running. A halt request enters idle or powerdown when the matching bit is armed. A wake-up (an enabled interrupt) returns the block to normal running. After powerdown, the clocks restart only once a programmable settling count has run out. Reset always restores full-speed running.

Top module: `pmclk_top`

## Requirements
- R1: In normal running with powersave off, cpu_clk_en and per_clk_en each pulse for one input cycle in every 2 input cycles, and clkout has a period of 2 input cycles and is high for 1 of them.
- R2: Control register (wr_sel=0) fields: bits[2:0] prescale code, bit3 powersave enable, bit4 idle arm, bit5 powerdown arm. With bit3 set, codes 0,1,2,3,4,5 give a factor N of 1,4,8,16,32,64, and codes 6 and 7 give 64. The enable period is then 2N input cycles and clkout is high for N of them. With bit3 clear, N is 1 whatever the code.
- R3: A new prescale factor takes effect only when the divided period in progress ends. The period that is running when the write lands keeps its old length.
- R4: A halt_req with only the idle arm set stops cpu_clk_en while per_clk_en keeps pulsing. A wake_irq pulse then restarts cpu_clk_en.
- R5: A halt_req with the powerdown arm set stops both enables and holds clkout at its level. The powerdown arm takes priority over the idle arm.
- R6: The settle register (wr_sel=1, all of wr_data) holds S. A wake_irq in powerdown keeps both enables low for S+1 input cycles, after which the divider resumes from where it froze. At a factor of 1 the first pulse is therefore seen on the (S+1)th or (S+2)th cycle after the wake cycle.
- R7: A halt_req with neither arm bit set has no effect. A halt_req that arrives in the same cycle as wake_irq does not leave normal running.
- R8: Reset clears the control register, loads the settle register with SETTLE_RST (default 3), and leaves the block in normal running at a factor of 1, including when reset arrives during powerdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Oscillator clock, twice the processor rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the settle register |
| wr_data | input | DATA_W | Write data |
| halt_req | input | 1 | Single-cycle halt request |
| wake_irq | input | 1 | Enabled interrupt that wakes the block |
| cpu_clk_en | output | 1 | CPU-domain clock enable pulse |
| per_clk_en | output | 1 | Peripheral-domain clock enable pulse |
| clkout | output | 1 | Processor-rate clock output with an even duty cycle |

## Verification
The assertions assume that rst_n is held across at least one clock edge and that halt_req and wake_irq arrive as synchronous signals. Under those conditions the state and the divider counter are always defined. The bench changes every input at the falling edge and holds it for one full period, so each request is seen at exactly one rising edge. It never issues a register write in the cycle that a halt or wake pulse is sampled, so a mode entry never overlaps a change to the arm bits.

// File: rtl/pmclk_pkg.sv
package pmclk_pkg;

  localparam int unsigned HALF_W = 7;   // holds half-period up to 64

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_DOWN   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_e;

  typedef struct packed {
    logic       pd_arm;
    logic       idle_arm;
    logic       psave_en;
    logic [2:0] code;
  } pm_ctrl_t;

  // Half period of the divided clock, in input cycles.
  function automatic logic [HALF_W-1:0] half_period(input logic psave,
                                                    input logic [2:0] code);
    if (!psave || code == 3'd0) return HALF_W'(1);
    else if (code >= 3'd5)      return HALF_W'(64);
    else                        return HALF_W'(1) << (code + 3'd1);
  endfunction

endpackage

// File: rtl/pmclk_regs.sv
module pmclk_regs
  import pmclk_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETTLE_RST = 3
)(
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output pm_ctrl_t          ctrl_o,
  output logic [DATA_W-1:0] settle_o
);
  localparam int unsigned CTRL_W = $bits(pm_ctrl_t);

  always_ff @(posedge clk_in) begin
    if (!rst_n) begin
      ctrl_o   <= '0;
      settle_o <= DATA_W'(SETTLE_RST);
    end else if (wr_en) begin
      if (wr_sel) settle_o <= wr_data;
      else        ctrl_o   <= pm_ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

endmodule

// File: rtl/pmclk_div.sv
module pmclk_div
  import pmclk_pkg::*;
(
  input  logic     clk_in,
  input  logic     rst_n,
  input  logic     run_i,
  input  pm_ctrl_t ctrl_i,
  output logic     tick_o,
  output logic     clkout_o
);
  localparam int unsigned CNT_W = HALF_W + 1;

  logic [HALF_W-1:0] half_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_w;
  logic              at_last_w;

  assign last_w    = {half_q, 1'b0} - CNT_W'(1);
  assign at_last_w = (cnt_q == last_w);
  assign tick_o    = run_i & at_last_w;
  assign clkout_o  = (cnt_q < {1'b0, half_q});

  always_ff @(posedge clk_in) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= HALF_W'(1);
    end else if (run_i) begin
      if (at_last_w) begin
        cnt_q  <= '0;
        half_q <= half_period(ctrl_i.psave_en, ctrl_i.code);
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R3: factor only changes right after a divided-period boundary
  a_r3_change_at_boundary: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$stable(half_q) |-> $past(tick_o));

  // R1: enable pulses are never back to back
  a_r1_pulse_spacing: assert property (@(posedge clk_in) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/pmclk_fsm.sv
module pmclk_fsm
  import pmclk_pkg::*;
#(
  parameter int unsigned SETTLE_W = 16
)(
  input  logic                clk_in,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                wake_irq,
  input  pm_ctrl_t            ctrl_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output pm_state_e           state_o,
  output logic                run_o
);
  logic [SETTLE_W-1:0] wait_q;

  assign run_o = (state_o == PM_RUN) || (state_o == PM_IDLE);

  always_ff @(posedge clk_in) begin
    if (!rst_n) begin
      state_o <= PM_RUN;
      wait_q  <= '0;
    end else begin
      case (state_o)
        PM_RUN: begin
          if (halt_req && !wake_irq) begin
            if (ctrl_i.pd_arm)        state_o <= PM_DOWN;
            else if (ctrl_i.idle_arm) state_o <= PM_IDLE;
          end
        end
        PM_IDLE: if (wake_irq) state_o <= PM_RUN;
        PM_DOWN: begin
          if (wake_irq) begin
            state_o <= PM_SETTLE;
            wait_q  <= settle_i;
          end
        end
        default: begin
          if (wait_q == '0) state_o <= PM_RUN;
          else              wait_q  <= wait_q - SETTLE_W'(1);
        end
      endcase
    end
  end

  // R7: a wake in the same cycle as a halt keeps normal running
  a_r7_wake_keeps_run: assert property (@(posedge clk_in) disable iff (!rst_n)
    (state_o == PM_RUN && wake_irq) |=> (state_o == PM_RUN));

  // R6: a wake in powerdown always passes through settling
  a_r6_wake_to_settle: assert property (@(posedge clk_in) disable iff (!rst_n)
    (state_o == PM_DOWN && wake_irq) |=> (state_o == PM_SETTLE));

endmodule

// File: rtl/pmclk_top.sv
module pmclk_top
  import pmclk_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETTLE_RST = 3
)(
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              halt_req,
  input  logic              wake_irq,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              clkout
);
  pm_ctrl_t          ctrl_w;
  logic [DATA_W-1:0] settle_w;
  pm_state_e         state_w;
  logic              run_w;
  logic              tick_w;

  pmclk_regs #(.DATA_W(DATA_W), .SETTLE_RST(SETTLE_RST)) regs_i (
    .clk_in(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_o(ctrl_w), .settle_o(settle_w));

  pmclk_fsm #(.SETTLE_W(DATA_W)) fsm_i (
    .clk_in(clk_in), .rst_n(rst_n), .halt_req(halt_req), .wake_irq(wake_irq),
    .ctrl_i(ctrl_w), .settle_i(settle_w), .state_o(state_w), .run_o(run_w));

  pmclk_div div_i (
    .clk_in(clk_in), .rst_n(rst_n), .run_i(run_w), .ctrl_i(ctrl_w),
    .tick_o(tick_w), .clkout_o(clkout));

  assign per_clk_en = tick_w;
  assign cpu_clk_en = tick_w & (state_w == PM_RUN);

  // R4: CPU domain never enabled while its peripherals run alone
  a_r4_idle_blocks_cpu: assert property (@(posedge clk_in) disable iff (!rst_n)
    (state_w == PM_IDLE) |-> !cpu_clk_en);

  // R4: CPU enable implies peripheral enable
  a_r4_cpu_within_per: assert property (@(posedge clk_in) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en);

  // R5: clock output held during powerdown
  a_r5_down_holds_clkout: assert property (@(posedge clk_in) disable iff (!rst_n)
    (state_w == PM_DOWN) |=> $stable(clkout));

  // R6: no enables while settling
  a_r6_settle_silent: assert property (@(posedge clk_in) disable iff (!rst_n)
    (state_w == PM_SETTLE) |-> !(per_clk_en || cpu_clk_en));

endmodule

// File: tb/pmclk_top_tb_top.sv
module pmclk_top_tb_top;
  localparam int unsigned DATA_W = 16;

  logic              clk_in = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              halt_req = 1'b0;
  logic              wake_irq = 1'b0;
  logic              cpu_clk_en, per_clk_en, clkout;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk_in = ~clk_in;   // 125 MHz

  pmclk_top dut_i (
    .clk_in(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .halt_req(halt_req), .wake_irq(wake_irq),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .clkout(clkout));

  // {control byte, expected enable period in input cycles}
  localparam logic [15:0] VEC [0:7] = '{
    16'h0502, 16'h0802, 16'h0908, 16'h0A10,
    16'h0B20, 16'h0C40, 16'h0D80, 16'h0F80 };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [DATA_W-1:0] d);
    @(negedge clk_in); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk_in); wr_en = 1'b0;
  endtask

  task automatic pulse_halt();
    @(negedge clk_in); halt_req = 1'b1;
    @(negedge clk_in); halt_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk_in); wake_irq = 1'b1;
    @(negedge clk_in); wake_irq = 1'b0;
  endtask

  task automatic wait_pulse();
    int guard = 0;
    do begin @(negedge clk_in); guard++; end
    while (!per_clk_en && guard < 1000);
  endtask

  // negedges from one per_clk_en pulse to the next, and clkout highs between
  task automatic measure(output int period, output int highs);
    wait_pulse();
    period = 0; highs = 0;
    do begin
      @(negedge clk_in); period++;
      if (clkout) highs++;
    end while (!per_clk_en && period < 1000);
  endtask

  task automatic count(input int cycles, output int cpu_n, output int per_n,
                       output int clk_chg);
    logic prev;
    cpu_n = 0; per_n = 0; clk_chg = 0;
    @(negedge clk_in); prev = clkout;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_in);
      if (cpu_clk_en) cpu_n++;
      if (per_clk_en) per_n++;
      if (clkout != prev) clk_chg++;
      prev = clkout;
    end
  endtask

  task automatic first_after_wake(output int idx);
    @(negedge clk_in); wake_irq = 1'b1;
    @(negedge clk_in); wake_irq = 1'b0;
    idx = 0;
    do begin @(negedge clk_in); idx++; end
    while (!per_clk_en && idx < 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk_in);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int p, h, c, pe, ch, idx;
    repeat (4) @(negedge clk_in);
    // R8: reset state
    check("R8 cpu_clk_en in reset", int'(cpu_clk_en), 0);
    check("R8 per_clk_en in reset", int'(per_clk_en), 0);
    check("R8 clkout in reset", int'(clkout), 1);
    rst_n = 1'b1;

    // R1: normal divide by two
    measure(p, h);
    check("R1 period", p, 2);
    check("R1 clkout high", h, 1);
    count(20, c, pe, ch);
    check("R1 cpu pulses", c, 10);

    // R2: prescale table
    for (int v = 0; v < 8; v++) begin
      write_reg(1'b0, DATA_W'(VEC[v][15:8]));
      measure(p, h);
      measure(p, h);
      measure(p, h);
      check($sformatf("R2 period ctrl=%0h", VEC[v][15:8]), p, int'(VEC[v][7:0]));
      check($sformatf("R2 clkout high ctrl=%0h", VEC[v][15:8]), h, int'(VEC[v][7:0]) / 2);
    end

    // R3: change mid-period keeps current period at 128, next is 8
    wait_pulse();
    p = 0;
    repeat (10) begin @(negedge clk_in); p++; end
    write_reg(1'b0, DATA_W'(8'h09)); p += 2;
    do begin @(negedge clk_in); p++; end while (!per_clk_en && p < 1000);
    check("R3 running period unchanged", p, 128);
    measure(p, h);
    check("R3 new period", p, 8);

    write_reg(1'b0, '0);
    measure(p, h); measure(p, h);
    check("R2 back to factor 1", p, 2);

    // R7: halt with nothing armed
    pulse_halt();
    count(20, c, pe, ch);
    check("R7 halt unarmed cpu pulses", c, 10);

    // R4: idle
    write_reg(1'b0, DATA_W'(8'h10));
    pulse_halt();
    count(40, c, pe, ch);
    check("R4 idle cpu pulses", c, 0);
    check("R4 idle per pulses", pe, 20);
    pulse_wake();
    count(20, c, pe, ch);
    check("R4 wake cpu pulses", c, 10);

    // R7: halt and wake together
    @(negedge clk_in); halt_req = 1'b1; wake_irq = 1'b1;
    @(negedge clk_in); halt_req = 1'b0; wake_irq = 1'b0;
    count(20, c, pe, ch);
    check("R7 halt+wake cpu pulses", c, 10);

    // R5: powerdown with both arms set, R6: settle of 5
    write_reg(1'b1, DATA_W'(5));
    write_reg(1'b0, DATA_W'(8'h30));
    pulse_halt();
    count(40, c, pe, ch);
    check("R5 down cpu pulses", c, 0);
    check("R5 down per pulses", pe, 0);
    check("R5 down clkout changes", ch, 0);
    first_after_wake(idx);
    check("R6 first pulse not before S+1", int'(idx >= 6), 1);
    check("R6 first pulse by S+2", int'(idx <= 7), 1);
    count(20, c, pe, ch);
    check("R6 running after settle", c, 10);

    // R8: reset during powerdown
    pulse_halt();
    count(10, c, pe, ch);
    check("R5 down again per pulses", pe, 0);
    @(negedge clk_in); rst_n = 1'b0;
    repeat (2) @(negedge clk_in); rst_n = 1'b1;
    measure(p, h);
    check("R8 period after reset", p, 2);
    pulse_halt();
    count(20, c, pe, ch);
    check("R8 control cleared", c, 10);
    write_reg(1'b0, DATA_W'(8'h20));
    pulse_halt();
    count(10, c, pe, ch);
    check("R8 powerdown per pulses", pe, 0);
    first_after_wake(idx);
    check("R8 default settle low bound", int'(idx >= 4), 1);
    check("R8 default settle high bound", int'(idx <= 5), 1);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule